// File: doc/BRIEF.md
# Pre/Post-Trigger Acquisition Controller

This block decides which pacer samples of an acquisition channel go into the channel's sample FIFO. It keeps a sliding history of samples taken before a start trigger. After the start trigger it writes every sample. When a stop trigger arrives, it writes a programmed tail of further samples and then stops writing. The FIFO is outside the block. The block gives it a write strobe and a discard-oldest strobe, and reads back only the FIFO's empty flag.

Software selects one of three modes: off, single capture, or repeating capture. In single capture the block stays finished after one capture. In repeating capture it waits until the FIFO has drained, then arms itself again, rebuilds the history and waits for the next start trigger. A status code, a set of sticky interrupt flags and a running period count report progress.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. Afterwards `status` is 0x00, `irq_flags` is 0, `period_count` is 0 and `fifo_wr` is low.
- R2: Mode encoding: bit 0 of `mode` is go and bit 1 selects repeating capture. With go at 0 (modes 2'b00 and 2'b10), the next clock edge gives `status` 0x00 and `period_count` 0, and no writes occur. With go at 1 from status 0x00, the next edge gives status 0x02 (waiting for start).
- R3: In status 0x02 with a nonzero `pre_count`, each `sample_tick` raises `fifo_wr` in that cycle. With `pre_count` at 0, ticks write nothing until the start trigger.
- R4: In status 0x02, once `pre_count` samples have been written since arming, every further write also raises `fifo_drop` in the same cycle, so the FIFO holds only the newest `pre_count` samples.
- R5: A `start_trig` in status 0x02 moves the block to status 0x03 at the next edge. After that, every tick writes. A `stop_trig` while waiting is ignored, and so is a `start_trig` while running.
- R6: A `stop_trig` while running sets flag bit 4. A tick in the same cycle is written as a running sample. The next `post_count` ticks are then written, and the last of them moves the block to status 0x07 and sets flag bit 5. With `post_count` at 0, the stop itself moves the block to status 0x07 and sets bit 5.
- R7: In status 0x07 no tick is written. Flag bit 6 is set at every edge where the status is 0x07 and `fifo_empty` is high.
- R8: In single capture, status 0x07 is held. In repeating capture, status 0x07 with `fifo_empty` high returns to status 0x02 at the next edge, and the history window restarts from zero samples.
- R9: `period_count` advances by one for every sample written in status 0x03. It does not advance in status 0x02. It keeps its value across a re-arm and is cleared only when go is 0.
- R10: Flag bit 7 is set by every `sample_tick` that occurs while go is 1 and the status is not 0x00.
- R11: Flags are sticky and are cleared by writing a 1 to the matching bit of `irq_clr`. A set and a clear of the same bit in the same cycle leave the bit set. Bits 3..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | bit 0 go, bit 1 repeating capture |
| pre_count | input | CNT_W | Samples of history kept before the start trigger |
| post_count | input | CNT_W | Samples written after the stop trigger |
| sample_tick | input | 1 | One-cycle pacer strobe, one per sample |
| start_trig | input | 1 | Start trigger strobe |
| stop_trig | input | 1 | Stop trigger strobe |
| fifo_empty | input | 1 | High when the sample FIFO holds nothing |
| irq_clr | input | 8 | Write-one-to-clear mask for the flags |
| fifo_wr | output | 1 | Write the current sample into the FIFO |
| fifo_drop | output | 1 | Discard the oldest FIFO entry together with this write |
| status | output | 8 | 0x00 stopped, 0x02 waiting for start, 0x03 running, 0x07 done |
| irq_flags | output | 8 | Sticky flags: bit 4 stop, bit 5 tail written, bit 6 drained, bit 7 tick |
| period_count | output | PER_W | Samples written since the start trigger, across re-arms |

## Verification
Two pairs of events can land in the same cycle. A pacer tick can coincide with the stop trigger, and a stop-flag clear can coincide with a stop trigger that sets that flag. The bench drives each pair in a single cycle. For the first pair, the scoreboard must see exactly one write, and the block must then still write the full tail of `post_count` samples. For the second pair, `irq_flags` bit 4 must read 1 after the edge.

// File: rtl/acq_pkg.sv
// Shared types and constants for the acquisition trigger controller.
// Assumes: status codes and flag bit positions are fixed by software.
package acq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_RUN,
        S_TAIL,
        S_DONE
    } acq_state_t;

    localparam logic [7:0] STAT_IDLE = 8'h00;
    localparam logic [7:0] STAT_ARM  = 8'h02;
    localparam logic [7:0] STAT_RUN  = 8'h03;
    localparam logic [7:0] STAT_DONE = 8'h07;

    localparam int IRQ_STOP  = 4;
    localparam int IRQ_TAIL  = 5;
    localparam int IRQ_DRAIN = 6;
    localparam int IRQ_TICK  = 7;

    // Maps an internal state to the software-visible status code.
    function automatic logic [7:0] status_of(acq_state_t s);
        case (s)
            S_ARM:         return STAT_ARM;
            S_RUN, S_TAIL: return STAT_RUN;
            S_DONE:        return STAT_DONE;
            default:       return STAT_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/acq_seq_fsm.sv
// Capture sequencer: walks idle -> armed -> running -> tail -> done and
// decides in which cycles a pacer tick becomes a FIFO write.
// Assumes: triggers and ticks are single-cycle strobes; go low overrides all.
module acq_seq_fsm
    import acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       rearm,
    input  logic       tick,
    input  logic       start_trig,
    input  logic       stop_trig,
    input  logic       fifo_empty,
    input  logic       pre_zero,
    input  logic       tail_zero,
    input  logic       tail_last,
    output acq_state_t state_q,
    output logic       wr_en,
    output logic       ev_stop,
    output logic       ev_tail_done
);

    acq_state_t state_d;

    // Next-state, write-accept and event decode.
    always_comb begin
        state_d      = state_q;
        wr_en        = 1'b0;
        ev_stop      = 1'b0;
        ev_tail_done = 1'b0;
        if (!go) begin
            state_d = S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: state_d = S_ARM;
                S_ARM: begin
                    wr_en = tick && !pre_zero;
                    if (start_trig) state_d = S_RUN;
                end
                S_RUN: begin
                    wr_en = tick;
                    if (stop_trig) begin
                        ev_stop = 1'b1;
                        if (tail_zero) begin
                            state_d      = S_DONE;
                            ev_tail_done = 1'b1;
                        end else begin
                            state_d = S_TAIL;
                        end
                    end
                end
                S_TAIL: begin
                    wr_en = tick;
                    if (tick && tail_last) begin
                        state_d      = S_DONE;
                        ev_tail_done = 1'b1;
                    end
                end
                S_DONE: begin
                    if (rearm && fifo_empty) state_d = S_ARM;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    AST_REARM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (go && rearm && fifo_empty && state_q == S_DONE) |=> state_q == S_ARM); // R8
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !rearm && state_q == S_DONE) |=> state_q == S_DONE); // R8
    AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE || state_q == S_IDLE) |-> !wr_en); // R7

endmodule

// File: rtl/acq_counters.sv
// Sample bookkeeping: history fill level, remaining tail samples and the
// running period count, plus the discard-oldest strobe for the history.
// Assumes: pre_count does not exceed the FIFO capacity.
module acq_counters
    import acq_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  acq_state_t       state,
    input  logic             wr_en,
    input  logic             ev_stop,
    input  logic [CNT_W-1:0] pre_count,
    input  logic [CNT_W-1:0] post_count,
    output logic             drop,
    output logic             pre_zero,
    output logic             tail_zero,
    output logic             tail_last,
    output logic [PER_W-1:0] period_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] pre_fill_q;
    logic [CNT_W-1:0] tail_left_q;
    logic             in_capture;

    assign in_capture = (state == S_RUN) || (state == S_TAIL);
    assign pre_zero   = (pre_count == '0);
    assign tail_zero  = (post_count == '0);
    assign tail_last  = (tail_left_q == ONE);
    assign drop       = (state == S_ARM) && wr_en && (pre_fill_q == pre_count);

    // History fill level, saturating at the window size; restarts on each arm.
    always_ff @(posedge clk) begin
        if (!rst_n || !go || state != S_ARM) pre_fill_q <= '0;
        else if (wr_en && pre_fill_q != pre_count) pre_fill_q <= pre_fill_q + ONE;
    end

    // Remaining tail samples, loaded at the stop trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || !go)                tail_left_q <= '0;
        else if (ev_stop)                 tail_left_q <= post_count;
        else if (state == S_TAIL && wr_en) tail_left_q <= tail_left_q - ONE;
    end

    // Running period count; survives re-arm, cleared only with go low.
    always_ff @(posedge clk) begin
        if (!rst_n || !go)           period_q <= '0;
        else if (wr_en && in_capture) period_q <= period_q + PER_W'(1);
    end

    AST_TAIL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TAIL) |-> tail_left_q != '0); // R6
    AST_PERIOD_FROZEN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (go && state == S_ARM) |=> $stable(period_q)); // R9

endmodule

// File: rtl/acq_irq_flags.sv
// Sticky interrupt flags with write-one-to-clear; a set beats a clear.
// Assumes: event inputs are single-cycle pulses from the sequencer.
module acq_irq_flags
    import acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  acq_state_t state,
    input  logic       tick,
    input  logic       ev_stop,
    input  logic       ev_tail_done,
    input  logic       fifo_empty,
    input  logic [7:0] irq_clr,
    output logic [7:0] irq_q
);

    logic [7:0] irq_set;

    // Collects this cycle's flag sources into their bit positions.
    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_STOP]  = ev_stop;
        irq_set[IRQ_TAIL]  = ev_tail_done;
        irq_set[IRQ_DRAIN] = (state == S_DONE) && fifo_empty;
        irq_set[IRQ_TICK]  = tick && go && (state != S_IDLE);
    end

    // Flag register: clear requested bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= (irq_q & ~irq_clr) | irq_set;
    end

    AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> irq_q[IRQ_STOP]); // R6
    AST_TICK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && go && state != S_IDLE) |=> irq_q[IRQ_TICK]); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q[IRQ_TAIL] && !irq_clr[IRQ_TAIL]) |=> irq_q[IRQ_TAIL]); // R11

endmodule

// File: rtl/acq_trigger_ctrl.sv
// Top of the pre/post-trigger acquisition controller: ties the sequencer,
// the sample counters and the flag register together.
// Assumes: the FIFO discards its oldest entry when fifo_drop accompanies a write.
module acq_trigger_ctrl
    import acq_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] pre_count,
    input  logic [CNT_W-1:0] post_count,
    input  logic             sample_tick,
    input  logic             start_trig,
    input  logic             stop_trig,
    input  logic             fifo_empty,
    input  logic [7:0]       irq_clr,
    output logic             fifo_wr,
    output logic             fifo_drop,
    output logic [7:0]       status,
    output logic [7:0]       irq_flags,
    output logic [PER_W-1:0] period_count
);

    logic       go;
    logic       rearm;
    acq_state_t state;
    logic       wr_en;
    logic       ev_stop;
    logic       ev_tail_done;
    logic       pre_zero;
    logic       tail_zero;
    logic       tail_last;

    assign go      = mode[0];
    assign rearm   = mode[1];
    assign fifo_wr = wr_en;
    assign status  = status_of(state);

    acq_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .rearm        (rearm),
        .tick         (sample_tick),
        .start_trig   (start_trig),
        .stop_trig    (stop_trig),
        .fifo_empty   (fifo_empty),
        .pre_zero     (pre_zero),
        .tail_zero    (tail_zero),
        .tail_last    (tail_last),
        .state_q      (state),
        .wr_en        (wr_en),
        .ev_stop      (ev_stop),
        .ev_tail_done (ev_tail_done)
    );

    acq_counters #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .state      (state),
        .wr_en      (wr_en),
        .ev_stop    (ev_stop),
        .pre_count  (pre_count),
        .post_count (post_count),
        .drop       (fifo_drop),
        .pre_zero   (pre_zero),
        .tail_zero  (tail_zero),
        .tail_last  (tail_last),
        .period_q   (period_count)
    );

    acq_irq_flags u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .state        (state),
        .tick         (sample_tick),
        .ev_stop      (ev_stop),
        .ev_tail_done (ev_tail_done),
        .fifo_empty   (fifo_empty),
        .irq_clr      (irq_clr),
        .irq_q        (irq_flags)
    );

    AST_DROP_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drop |-> (status == STAT_ARM && fifo_wr)); // R4
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (status == STAT_IDLE && period_count == '0)); // R2

endmodule

// File: tb/acq_trigger_ctrl_bench.sv
// Scoreboard bench: the driver queues the expected writes (with their discard
// flag) and a monitor compares them with fifo_wr/fifo_drop every cycle.
module acq_trigger_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [9:0]  pre_n = 10'd3;
    logic [9:0]  post_n = 10'd2;
    logic        tick = 1'b0;
    logic        start_t = 1'b0;
    logic        stop_t = 1'b0;
    logic        empty = 1'b0;
    logic [7:0]  clr = 8'h00;
    logic        wr;
    logic        drop;
    logic [7:0]  status;
    logic [7:0]  irq;
    logic [31:0] period;

    int n_chk = 0;
    int n_err = 0;
    bit exp_q[$];

    always #2 clk = ~clk;

    acq_trigger_ctrl u_acq_trigger_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .pre_count    (pre_n),
        .post_count   (post_n),
        .sample_tick  (tick),
        .start_trig   (start_t),
        .stop_trig    (stop_t),
        .fifo_empty   (empty),
        .irq_clr      (clr),
        .fifo_wr      (wr),
        .fifo_drop    (drop),
        .status       (status),
        .irq_flags    (irq),
        .period_count (period)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one cycle of stimulus and queues the expected write, if any.
    task automatic step(input logic t, input logic s, input logic p,
                        input logic [7:0] c, input logic ew, input logic ed);
        @(negedge clk);
        tick = t; start_t = s; stop_t = p; clr = c;
        if (ew) exp_q.push_back(ed);
    endtask

    // Moves just past the next rising edge so registered outputs are settled.
    task automatic look();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares actual writes against the queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (wr) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected write", 32'd1, 32'd0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk("R4 write drop flag", {31'd0, drop}, {31'd0, e});
                end
            end else if (exp_q.size() != 0) begin
                chk("R3 missing write", 32'd0, 32'd1);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #800000;
        n_err++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        look();
        chk("R1 status", {24'd0, status}, 32'h00);
        chk("R1 flags", {24'd0, irq}, 32'h00);
        chk("R1 period", period, 32'd0);

        // Single capture, window 3, tail 2.
        mode = 2'b01;
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R2 armed status", {24'd0, status}, 32'h02);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 8'h00, 1, i >= 3);
        look();
        chk("R10 tick flag", {31'd0, irq[7]}, 32'd1);
        chk("R11 low bits zero", {28'd0, irq[3:0]}, 32'd0);
        step(0, 0, 0, 8'h80, 0, 0); look();
        chk("R11 clear tick flag", {31'd0, irq[7]}, 32'd0);
        step(0, 0, 1, 8'h00, 0, 0); look();
        chk("R5 stop ignored while waiting", {24'd0, status}, 32'h02);
        chk("R5 no stop flag", {31'd0, irq[4]}, 32'd0);
        chk("R9 no count while waiting", period, 32'd0);
        step(0, 1, 0, 8'h00, 0, 0); look();
        chk("R5 running", {24'd0, status}, 32'h03);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00, 1, 0);
        step(0, 1, 0, 8'h00, 0, 0); look();
        chk("R9 running count", period, 32'd3);
        chk("R5 start ignored while running", {24'd0, status}, 32'h03);
        // Tick and stop in the same cycle: a running sample.
        step(1, 0, 1, 8'h00, 1, 0); look();
        chk("R6 stop flag", {31'd0, irq[4]}, 32'd1);
        chk("R6 tail status", {24'd0, status}, 32'h03);
        step(1, 0, 0, 8'h00, 1, 0); look();
        chk("R6 tail not yet done", {24'd0, status}, 32'h03);
        step(1, 0, 0, 8'h00, 1, 0); look();
        chk("R6 done status", {24'd0, status}, 32'h07);
        chk("R6 tail flag", {31'd0, irq[5]}, 32'd1);
        chk("R9 count incl tail", period, 32'd6);
        chk("R7 no drain flag while not empty", {31'd0, irq[6]}, 32'd0);
        step(1, 0, 0, 8'h00, 0, 0);
        empty = 1'b1;
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R7 drain flag", {31'd0, irq[6]}, 32'd1);
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R8 single holds done", {24'd0, status}, 32'h07);

        // Off mode, then repeating capture with zero tail.
        mode = 2'b00;
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R2 off status", {24'd0, status}, 32'h00);
        chk("R2 off clears period", period, 32'd0);
        step(0, 0, 0, 8'hFF, 0, 0); look();
        chk("R11 clear all", {24'd0, irq}, 32'h00);
        empty = 1'b0; post_n = 10'd0; mode = 2'b11;
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R2 repeat armed", {24'd0, status}, 32'h02);
        step(1, 0, 0, 8'h00, 1, 0);
        step(1, 0, 0, 8'h00, 1, 0);
        step(0, 1, 0, 8'h00, 0, 0);
        step(1, 0, 0, 8'h00, 1, 0);
        // Stop together with a clear of the stop flag: set wins.
        step(0, 0, 1, 8'h10, 0, 0); look();
        chk("R6 zero tail done", {24'd0, status}, 32'h07);
        chk("R11 set beats clear", {31'd0, irq[4]}, 32'd1);
        chk("R6 zero tail flag", {31'd0, irq[5]}, 32'd1);
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R8 waits for drain", {24'd0, status}, 32'h07);
        empty = 1'b1;
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R8 re-armed", {24'd0, status}, 32'h02);
        chk("R7 drain flag repeat", {31'd0, irq[6]}, 32'd1);
        chk("R9 count kept across re-arm", period, 32'd1);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 8'h00, 1, i >= 3);
        step(0, 0, 0, 8'h00, 0, 0);

        // Zero history: ticks while waiting write nothing.
        mode = 2'b10; pre_n = 10'd0;
        step(0, 0, 0, 8'hFF, 0, 0); look();
        chk("R2 mode 2 is off", {24'd0, status}, 32'h00);
        mode = 2'b11;
        step(0, 0, 0, 8'h00, 0, 0);
        step(1, 0, 0, 8'h00, 0, 0);
        step(1, 0, 0, 8'h00, 0, 0); look();
        chk("R10 tick flag without write", {31'd0, irq[7]}, 32'd1);
        chk("R3 zero history waiting", {24'd0, status}, 32'h02);
        step(0, 1, 0, 8'h00, 0, 0);
        step(1, 0, 0, 8'h00, 1, 0);
        step(0, 0, 0, 8'h00, 0, 0); look();
        chk("R9 count after zero history", period, 32'd1);
        repeat (3) @(posedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule